// File: doc/BRIEF.md
# Rotated Gray-Code Flip-Position Sequencer

This block produces, one entry per clock cycle, the list of bit positions at which a binary-reflected Gray code over `n` bits changes. Each position is offset by a rotation amount `s` and wrapped modulo `n`. The block does not produce the codewords themselves. A caller pulses `startPulse` with a width and an offset. The block then sends out steps `t = 1 .. 2^n - 1` on consecutive cycles, and each step carries its index and its rotated flip position. The final step is flagged.

The unrotated list has a recursive definition. For one bit it is the single entry 0. For `n` bits it is the `(n-1)`-bit list, then the value `n-1`, then the `(n-1)`-bit list again. The entry at step `t` is the number of trailing zero bits of `t`, so the block computes it straight from a step counter. Applying the emitted positions in order as single-bit flips, starting from any `n`-bit value, visits all `2^n` values exactly once. A consumer uses this to sweep every neighbour dimension of a cube in a balanced order, with a different rotation per instance.

Top module: `gray_flip_seq`

## Requirements
- R1: While reset is held, and after it is released with no start, `stepValid` and `runDone` are 0 and `stepIndex` is 0.
- R2: A start pulse with a valid setting, sampled at a clock edge while idle, makes `stepValid` high from the next cycle. `stepIndex` reads 1 in that cycle, rises by exactly one each cycle, and covers 1 through `2^n - 1` with no gaps.
- R3: With offset 0, `dimOut` at step `t` equals the count of trailing zeros of `t`. For `n = 3` the order is 0,1,0,2,0,1,0.
- R4: With offset `s`, `dimOut` equals (trailing zeros of `t` + `s`) mod `n` and is always below `n`. For `n = 3`, `s = 1` the order is 1,2,1,0,1,2,1.
- R5: `runDone` is high only together with the step `t = 2^n - 1`. In the cycle after it, `stepValid` is low.
- R6: A start pulse that arrives while a run is in progress is ignored. The ongoing run keeps its width and offset and its full step count.
- R7: A start pulse whose width is 0, whose width exceeds `MAX_WIDTH` (8), or whose offset is not below the width is ignored, and no step follows it.
- R8: XOR-ing a one-hot mask at each emitted position into a running value, starting from 0, visits each of the `2^n` values exactly once, for every width 1 to 8.
- R9: For `n = 1` the run is a single step with `stepIndex` 1, `dimOut` 0 and `runDone` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Requests a new run when idle |
| widthIn | input | 4 | Code width `n`, 1 to 8 |
| offsetIn | input | 3 | Rotation offset `s`, below `n` |
| stepValid | output | 1 | High on each cycle that carries a step |
| stepIndex | output | 8 | Step number `t` |
| dimOut | output | 3 | Rotated flip position for step `t` |
| runDone | output | 1 | High together with the last step |

## Verification
The corner cases are the widths at both ends (`n = 1` and `n = 8`), an offset of `n-1` where the modulo wrap happens on almost every step, and start pulses that arrive mid-run or with an illegal setting. A design with a wrong wrap (subtracting at `>` instead of `>=`) emits a position equal to `n`. An off-by-one last-step compare shows up as a missing or extra step and an early or late `runDone`. A design that reloads on a mid-run start restarts `stepIndex`. The XOR walk catches any trailing-zero error, because a wrong position revisits a codeword.

// File: rtl/gray_flip_pkg.sv
package gray_flip_pkg;
  typedef struct packed {
    logic load;     // capture settings and set the counter to 1
    logic advance;  // step the counter
    logic finish;   // last step of the run is being presented
  } ctrlStrobe_t;
endpackage

// File: rtl/gray_flip_ctrl.sv
module gray_flip_ctrl
  import gray_flip_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        cfgOk,
  input  logic        lastStep,
  output ctrlStrobe_t strb,
  output logic        running
);
  typedef enum logic {S_IDLE, S_RUN} state_t;
  state_t state;

  always_comb begin
    strb.load    = (state == S_IDLE) && startPulse && cfgOk;
    strb.advance = (state == S_RUN) && !lastStep;
    strb.finish  = (state == S_RUN) && lastStep;
  end

  assign running = (state == S_RUN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else if (strb.load) begin
      state <= S_RUN;
    end else if (strb.finish) begin
      state <= S_IDLE;
    end
  end

  // R5: after the last step the run stops
  p_idle_after_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !running);
  // R6: a load never happens while a run is active
  p_no_reload_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (running && startPulse) |=> (running || $past(strb.finish)));
  // R2: an accepted start yields a valid step on the next cycle
  p_start_runs_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> running);
endmodule

// File: rtl/gray_flip_dp.sv
module gray_flip_dp
  import gray_flip_pkg::*;
#(
  parameter int MAX_WIDTH = 8,
  parameter int WW = $clog2(MAX_WIDTH + 1),
  parameter int DW = $clog2(MAX_WIDTH),
  parameter int SW = MAX_WIDTH
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strb,
  input  logic          active,
  input  logic [WW-1:0] widthIn,
  input  logic [DW-1:0] offsetIn,
  output logic          cfgOk,
  output logic          lastStep,
  output logic [SW-1:0] stepCnt,
  output logic [DW-1:0] dimOut
);
  localparam int EW = DW + 1;

  logic [WW-1:0] wReg;
  logic [DW-1:0] oReg;
  logic [SW:0]   lastVal;
  logic [DW-1:0] ctzVal;
  logic [EW-1:0] sumVal;
  logic [EW-1:0] wExt;

  assign cfgOk = (widthIn != '0) && (widthIn <= WW'(MAX_WIDTH)) &&
                 (EW'(offsetIn) < EW'(widthIn));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wReg    <= '0;
      oReg    <= '0;
      stepCnt <= '0;
    end else if (strb.load) begin
      wReg    <= widthIn;
      oReg    <= offsetIn;
      stepCnt <= SW'(1);
    end else if (strb.advance) begin
      stepCnt <= stepCnt + SW'(1);
    end
  end

  assign lastVal  = ((SW+1)'(1) << wReg) - (SW+1)'(1);
  assign lastStep = (stepCnt == lastVal[SW-1:0]);

  // trailing-zero count, lowest set bit wins
  always_comb begin
    ctzVal = '0;
    for (int i = SW - 1; i >= 0; i--) begin
      if (stepCnt[i]) ctzVal = DW'(i);
    end
  end

  // both operands are below the width, so one conditional subtract suffices
  assign wExt   = EW'(wReg);
  assign sumVal = EW'(ctzVal) + EW'(oReg);
  always_comb begin
    if (sumVal >= wExt) dimOut = DW'(sumVal - wExt);
    else                dimOut = DW'(sumVal);
  end

  // R4: the emitted position is always below the width
  p_dim_below_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (EW'(dimOut) < wExt));
  // R2: first step index is one
  p_first_index_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (stepCnt == SW'(1)));
  // R2: the index rises by one per step
  p_index_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (stepCnt == $past(stepCnt) + SW'(1)));
  // R6: settings hold during a run
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    active |=> ($stable(wReg) && $stable(oReg)));
endmodule

// File: rtl/gray_flip_seq.sv
module gray_flip_seq
  import gray_flip_pkg::*;
#(
  parameter int MAX_WIDTH = 8,
  localparam int WW = $clog2(MAX_WIDTH + 1),
  localparam int DW = $clog2(MAX_WIDTH),
  localparam int SW = MAX_WIDTH
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic [WW-1:0] widthIn,
  input  logic [DW-1:0] offsetIn,
  output logic          stepValid,
  output logic [SW-1:0] stepIndex,
  output logic [DW-1:0] dimOut,
  output logic          runDone
);
  ctrlStrobe_t strb;
  logic cfgOk;
  logic lastStep;
  logic running;

  gray_flip_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cfgOk(cfgOk),
    .lastStep(lastStep), .strb(strb), .running(running)
  );

  gray_flip_dp #(.MAX_WIDTH(MAX_WIDTH), .WW(WW), .DW(DW), .SW(SW)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .active(running),
    .widthIn(widthIn), .offsetIn(offsetIn), .cfgOk(cfgOk),
    .lastStep(lastStep), .stepCnt(stepIndex), .dimOut(dimOut)
  );

  assign stepValid = running;
  assign runDone   = running && lastStep;

  // R5: done only together with a valid step
  p_done_with_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    runDone |-> stepValid);
endmodule

// File: tb/test_gray_flip_seq.sv
module test_gray_flip_seq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [3:0] widthIn = 4'd0;
  logic [2:0] offsetIn = 3'd0;
  logic       stepValid;
  logic [7:0] stepIndex;
  logic [2:0] dimOut;
  logic       runDone;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit monOn = 0;

  // reference model state
  bit mActive = 0;
  int mT = 0, mN = 1, mS = 0;

  // coverage walk state
  bit seen[256];
  int walkVal = 0, stepsSeen = 0, dupHits = 0;
  int dimLog[$];

  always #4 clk = ~clk;

  gray_flip_seq i_gray_flip_seq (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .widthIn(widthIn),
    .offsetIn(offsetIn), .stepValid(stepValid), .stepIndex(stepIndex),
    .dimOut(dimOut), .runDone(runDone)
  );

  function automatic int tz(int v);
    int c = 0;
    while (v[0] == 1'b0 && c < 31) begin v = v >> 1; c++; end
    return c;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0d", req, act, exp, mT);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) mActive = 0;
    else if (!mActive) begin
      if (startPulse && widthIn >= 1 && widthIn <= 8 && offsetIn < widthIn) begin
        mActive = 1; mT = 1; mN = int'(widthIn); mS = int'(offsetIn);
      end
    end else if (mT == (1 << mN) - 1) mActive = 0;
    else mT++;
  end

  always @(negedge clk) begin
    if (monOn) begin
      chk(stepValid == mActive, "R2 valid", stepValid, mActive);
      if (mActive) begin
        chk(int'(stepIndex) == mT, "R2 index", stepIndex, mT);
        chk(int'(dimOut) == (tz(mT) + mS) % mN, (mS == 0) ? "R3 dim" : "R4 dim",
            dimOut, (tz(mT) + mS) % mN);
        chk(runDone == (mT == (1 << mN) - 1), (mN == 1) ? "R9 done" : "R5 done",
            runDone, (mT == (1 << mN) - 1));
        if (stepValid) begin
          stepsSeen++;
          dimLog.push_back(int'(dimOut));
          walkVal = walkVal ^ (1 << dimOut);
          if (walkVal < 256) begin
            if (seen[walkVal]) dupHits++;
            seen[walkVal] = 1;
          end
        end
      end else begin
        chk(runDone == 1'b0, "R5 idle done", runDone, 0);
      end
    end
  end

  task automatic clearWalk();
    foreach (seen[i]) seen[i] = 0;
    seen[0] = 1; walkVal = 0; stepsSeen = 0; dupHits = 0;
    dimLog.delete();
  endtask

  task automatic pulseStart(int n, int s);
    @(negedge clk);
    startPulse = 1; widthIn = 4'(n); offsetIn = 3'(s);
    @(negedge clk);
    startPulse = 0;
  endtask

  task automatic runSeq(int n, int s, bit midStart);
    int nSeen;
    clearWalk();
    pulseStart(n, s);
    if (midStart && n > 2) begin
      @(negedge clk);
      startPulse = 1; widthIn = 4'd2; offsetIn = 3'd1;
      @(negedge clk);
      startPulse = 0;
    end
    while (mActive) @(negedge clk);
    @(negedge clk);
    nSeen = 0;
    foreach (seen[i]) if (seen[i]) nSeen++;
    chk(dupHits == 0 && nSeen == (1 << n), "R8 walk", nSeen, 1 << n);
    if (midStart) chk(stepsSeen == (1 << n) - 1, "R6 steps", stepsSeen, (1 << n) - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(stepValid == 0 && runDone == 0 && stepIndex == 0, "R1 in reset",
        stepValid, 0);
    rstN = 1;
    @(negedge clk);
    chk(stepValid == 0 && runDone == 0 && stepIndex == 0, "R1 after reset",
        int'(stepIndex), 0);
    monOn = 1;

    // R3 explicit order
    runSeq(3, 0, 0);
    begin
      int exp0[7] = '{0, 1, 0, 2, 0, 1, 0};
      for (int i = 0; i < 7; i++)
        chk(dimLog.size() == 7 && dimLog[i] == exp0[i], "R3 order",
            (dimLog.size() > i) ? dimLog[i] : -1, exp0[i]);
    end
    // R4 explicit order
    runSeq(3, 1, 0);
    begin
      int exp1[7] = '{1, 2, 1, 0, 1, 2, 1};
      for (int i = 0; i < 7; i++)
        chk(dimLog.size() == 7 && dimLog[i] == exp1[i], "R4 order",
            (dimLog.size() > i) ? dimLog[i] : -1, exp1[i]);
    end
    // R9 single-bit width
    runSeq(1, 0, 0);
    chk(stepsSeen == 1, "R9 one step", stepsSeen, 1);

    // R8 all widths, offset 0 and n-1
    for (int n = 1; n <= 8; n++) begin
      runSeq(n, 0, 0);
      runSeq(n, n - 1, 0);
    end
    runSeq(5, 2, 0);

    // R6 start during a run
    runSeq(4, 3, 1);
    runSeq(6, 1, 1);

    // R7 illegal settings
    pulseStart(0, 0);
    repeat (3) @(negedge clk);
    chk(stepValid == 0, "R7 width0", stepValid, 0);
    pulseStart(9, 0);
    repeat (3) @(negedge clk);
    chk(stepValid == 0, "R7 width9", stepValid, 0);
    pulseStart(3, 3);
    repeat (3) @(negedge clk);
    chk(stepValid == 0, "R7 offset", stepValid, 0);
    pulseStart(1, 1);
    repeat (3) @(negedge clk);
    chk(stepValid == 0, "R7 offset1", stepValid, 0);

    // back-to-back runs still work afterwards
    runSeq(2, 1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule